// File: doc/BRIEF.md
# Video InfoFrame Packet Generator

This block stores the contents of three side-channel packets for a display link: auxiliary-video, audio and vendor-specific. At each rising edge of vertical sync it sends every enabled packet as a byte stream. Software fills the control, header and payload registers through a byte-wide write port. The block computes each packet checksum in hardware, makes it readable, and places it in the stream between the header and the payload.

A sequence starts when the sync rises. At that moment the block takes a snapshot of all registers into a transmit bank. Register writes made while a sequence is running therefore only affect the next sync. When a legacy DVI-style mode input is asserted, the block sends nothing, whatever the enables say.

Top module: `infoframe_gen`

## Requirements
- R1: After reset the header bytes (type, version, length) read back as 0x82/0x02/0x0D for slot 0 (auxiliary-video), 0x84/0x01/0x0A for slot 1 (audio) and 0x81/0x01/0x00 for slot 2 (vendor-specific). All control registers read 0. Auxiliary-video payload byte 2 reads 0x28 (16:9 aspect, value 2 in bits 5:4, with same-as-picture coding 8 in bits 3:0) and byte 4 reads the DEF_VIC parameter. Every other payload byte reads 0. No packet is output.
- R2: Address bits 7:6 select the slot (0, 1 or 2; slot 3 is unmapped). Bits 5:0 select the register: 0 is control, 1 to 3 are header bytes 0 to 2, 4 is the read-only checksum, and 8+(n-1) is payload byte n for n from 1 to PAY_DEPTH. Writes to the checksum or to unmapped addresses change nothing. Reads of unmapped addresses return 0.
- R3: The checksum register reads the two's complement of the low 8 bits of the sum of the three header bytes and payload bytes 1..L, where L = min(header byte 2, PAY_DEPTH). It reflects a write in the cycle after that write.
- R4: Slot 0 is enabled when bit 1 of its control register is set. Slots 1 and 2 are enabled when their control register is nonzero.
- R5: A vsync_i rise is sampled at a clock edge. From the next cycle, each enabled packet is sent one byte per cycle with pkt_valid_o high, in this order: header byte 0, header byte 1, header byte 2, checksum, then payload bytes 1..L. pkt_sop_o is high only with header byte 0, and pkt_slot_o gives the slot number.
- R6: When several packets are enabled, they are sent back to back with no idle cycle, in slot order 0, 1, 2.
- R7: If header byte 2 exceeds PAY_DEPTH, exactly PAY_DEPTH payload bytes are sent and the header byte goes out unchanged.
- R8: If dvi_mode_i is high at a vsync rise, nothing is sent. If it rises during a sequence, pkt_valid_o is low from the next cycle and the rest of the sequence is dropped.
- R9: The bytes sent are the register values at the vsync rise. Writes made during a sequence appear only from the next vsync.
- R10: A vsync rise during a running sequence is ignored. It neither restarts the sequence nor adds packets.
- R11: A vsync rise with no slot enabled produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address: slot in bits 7:6, register in bits 5:0 |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Read address, same layout as the write address |
| rd_data_o | output | 8 | Read data, combinational |
| vsync_i | input | 1 | Vertical sync, synchronous to clk_i |
| dvi_mode_i | input | 1 | Suppresses all packets when high |
| pkt_valid_o | output | 1 | Stream byte valid |
| pkt_sop_o | output | 1 | First byte of a packet |
| pkt_data_o | output | 8 | Stream byte |
| pkt_slot_o | output | 2 | Slot of the packet being sent |

## Verification
A wrong sum or a wrong length clamp inside a slot shows up in two places: at the checksum read port in the cycle after the write, and as the fourth byte of that slot's next packet. A broken byte counter shows up as a packet that is too short or too long. The bench detects it when the next start strobe arrives early or late, or when the total byte count after one sync is wrong. A snapshot taken at the wrong time, or a sync rise that is not ignored while busy, shows up within the same sequence as mixed old and new payload or as a restarted stream. A lost DVI abort shows up one cycle after the mode input rises.

// File: rtl/ifg_pkg.sv
package ifg_pkg;
  localparam int NSLOT     = 3;
  localparam int SLOT_W    = 2;
  localparam int SLOT_AVI  = 0;
  localparam int SLOT_AUD  = 1;
  localparam int SLOT_VSP  = 2;
  localparam logic [7:0] TYPE_BASE = 8'h80;
  localparam int OFF_CTRL  = 0;
  localparam int OFF_HDR   = 1;
  localparam int OFF_CHK   = 4;
  localparam int OFF_PAY   = 8;

  typedef logic [7:0] ifg_byte_t;

  function automatic ifg_byte_t def_hdr(int slot, int i);
    ifg_byte_t t, v, l;
    case (slot)
      SLOT_AVI: begin t = TYPE_BASE + 8'd2; v = 8'h02; l = 8'h0D; end
      SLOT_AUD: begin t = TYPE_BASE + 8'd4; v = 8'h01; l = 8'h0A; end
      default:  begin t = TYPE_BASE + 8'd1; v = 8'h01; l = 8'h00; end
    endcase
    case (i)
      0:       return t;
      1:       return v;
      default: return l;
    endcase
  endfunction

  // n is 1-based
  function automatic ifg_byte_t def_pay(int slot, int n, ifg_byte_t vic);
    if (slot == SLOT_AVI && n == 2) return {2'b00, 2'd2, 4'd8};
    if (slot == SLOT_AVI && n == 4) return vic;
    return 8'h00;
  endfunction
endpackage

// File: rtl/ifg_chksum.sv
module ifg_chksum #(
  parameter int PAY_DEPTH = 27,
  parameter int LEN_W     = 5
) (
  input  logic [2:0][7:0]           hdr_i,
  input  logic [PAY_DEPTH-1:0][7:0] pay_i,
  output logic [7:0]                chk_o,
  output logic [LEN_W-1:0]          len_o
);
  logic [7:0] acc;

  always_comb begin
    if (hdr_i[2] > 8'(PAY_DEPTH)) len_o = LEN_W'(PAY_DEPTH);
    else                          len_o = LEN_W'(hdr_i[2]);
  end

  always_comb begin
    acc = hdr_i[0] + hdr_i[1] + hdr_i[2];
    for (int i = 0; i < PAY_DEPTH; i++)
      if (LEN_W'(i) < len_o) acc = acc + pay_i[i];
    chk_o = 8'h00 - acc;
  end
endmodule

// File: rtl/ifg_slot.sv
module ifg_slot
  import ifg_pkg::*;
#(
  parameter int         SLOT_ID   = 0,
  parameter int         PAY_DEPTH = 27,
  parameter int         OFF_W     = 6,
  parameter int         LEN_W     = 5,
  parameter int         IDX_W     = 5,
  parameter logic [7:0] DEF_VIC   = 8'd16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [7:0]       wr_data_i,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic [7:0]       rd_data_o,
  input  logic             snap_i,
  output logic             en_o,
  output logic [LEN_W-1:0] len_o,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  logic [7:0]                ctrl_q;
  logic [2:0][7:0]           hdr_q, a_hdr_q;
  logic [PAY_DEPTH-1:0][7:0] pay_q, a_pay_q;
  logic [7:0]                a_chk_q, chk_w;
  logic [LEN_W-1:0]          a_len_q, len_w;
  int wo, ro, bi;

  assign wo = int'(wr_off_i);
  assign ro = int'(rd_off_i);
  assign bi = int'(idx_i) - 4;

  ifg_chksum #(.PAY_DEPTH(PAY_DEPTH), .LEN_W(LEN_W)) i_chksum (
    .hdr_i(hdr_q), .pay_i(pay_q), .chk_o(chk_w), .len_o(len_w)
  );

  // software-visible bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      for (int i = 0; i < 3; i++) hdr_q[i] <= def_hdr(SLOT_ID, i);
      for (int n = 0; n < PAY_DEPTH; n++) pay_q[n] <= def_pay(SLOT_ID, n + 1, DEF_VIC);
    end else if (wr_en_i) begin
      if (wo == OFF_CTRL) ctrl_q <= wr_data_i;
      for (int i = 0; i < 3; i++)
        if (wo == OFF_HDR + i) hdr_q[i] <= wr_data_i;
      for (int n = 0; n < PAY_DEPTH; n++)
        if (wo == OFF_PAY + n) pay_q[n] <= wr_data_i;
    end
  end

  // transmit bank, frozen between snapshots
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_hdr_q <= '0;
      a_pay_q <= '0;
      a_chk_q <= '0;
      a_len_q <= '0;
    end else if (snap_i) begin
      a_hdr_q <= hdr_q;
      a_pay_q <= pay_q;
      a_chk_q <= chk_w;
      a_len_q <= len_w;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (ro == OFF_CTRL) rd_data_o = ctrl_q;
    if (ro == OFF_CHK)  rd_data_o = chk_w;
    for (int i = 0; i < 3; i++)
      if (ro == OFF_HDR + i) rd_data_o = hdr_q[i];
    for (int n = 0; n < PAY_DEPTH; n++)
      if (ro == OFF_PAY + n) rd_data_o = pay_q[n];
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < 3; i++)
      if (int'(idx_i) == i) byte_o = a_hdr_q[i];
    if (int'(idx_i) == 3) byte_o = a_chk_q;
    for (int n = 0; n < PAY_DEPTH; n++)
      if (bi == n) byte_o = a_pay_q[n];
  end

  generate
    if (SLOT_ID == SLOT_AVI) begin : g_avi_policy
      assign en_o = ctrl_q[1];
    end else begin : g_any_policy
      assign en_o = |ctrl_q;
    end
  endgenerate

  assign len_o = a_len_q;

  // R9: transmit bank only moves on a snapshot
  a_r9_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(a_hdr_q) && $stable(a_pay_q) && $stable(a_chk_q) && $stable(a_len_q));
endmodule

// File: rtl/ifg_seq.sv
module ifg_seq #(
  parameter int NSLOT  = 3,
  parameter int LEN_W  = 5,
  parameter int IDX_W  = 5,
  parameter int SLOT_W = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        vsync_i,
  input  logic                        dvi_mode_i,
  input  logic [NSLOT-1:0]            en_i,
  input  logic [NSLOT-1:0][LEN_W-1:0] len_i,
  output logic                        snap_o,
  output logic                        valid_o,
  output logic                        sop_o,
  output logic [SLOT_W-1:0]           slot_o,
  output logic [IDX_W-1:0]            idx_o
);
  logic              vs_q, busy_q;
  logic [SLOT_W-1:0] slot_q;
  logic [IDX_W-1:0]  idx_q, last_w;
  logic [NSLOT-1:0]  pend_q, pend_nxt;
  logic              rise_w;

  function automatic logic [SLOT_W-1:0] first_set(logic [NSLOT-1:0] m);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (m[i]) r = SLOT_W'(i);
    return r;
  endfunction

  assign rise_w   = vsync_i & ~vs_q;
  assign snap_o   = rise_w & ~busy_q & ~dvi_mode_i;
  assign last_w   = IDX_W'(len_i[slot_q]) + IDX_W'(3);
  assign pend_nxt = pend_q & ~(NSLOT'(1) << slot_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_q <= 1'b0;
    else         vs_q <= vsync_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      idx_q  <= '0;
      pend_q <= '0;
    end else if (dvi_mode_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      pend_q <= '0;
    end else if (!busy_q) begin
      if (snap_o && |en_i) begin
        busy_q <= 1'b1;
        pend_q <= en_i;
        slot_q <= first_set(en_i);
        idx_q  <= '0;
      end
    end else if (idx_q == last_w) begin
      idx_q  <= '0;
      pend_q <= pend_nxt;
      if (|pend_nxt) slot_q <= first_set(pend_nxt);
      else           busy_q <= 1'b0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign valid_o = busy_q;
  assign sop_o   = busy_q && (idx_q == '0);
  assign slot_o  = slot_q;
  assign idx_o   = idx_q;

  a_r8_dvi_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvi_mode_i |=> !valid_o);
  a_r5_starts_with_sop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(valid_o)) |-> sop_o);
  a_r5_packet_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_o && $past(valid_o)) |-> $past(idx_q == last_w));
  a_r6_slot_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_o && $past(valid_o)) |-> (slot_o > $past(slot_o)));
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !sop_o) |-> (idx_q == IDX_W'($past(idx_q) + 1'b1)));
endmodule

// File: rtl/infoframe_gen.sv
module infoframe_gen
  import ifg_pkg::*;
#(
  parameter int         PAY_DEPTH = 27,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] DEF_VIC   = 8'd16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              vsync_i,
  input  logic              dvi_mode_i,
  output logic              pkt_valid_o,
  output logic              pkt_sop_o,
  output logic [7:0]        pkt_data_o,
  output logic [SLOT_W-1:0] pkt_slot_o
);
  localparam int OFF_W = ADDR_W - SLOT_W;
  localparam int LEN_W = $clog2(PAY_DEPTH + 1);
  localparam int IDX_W = $clog2(PAY_DEPTH + 4);

  logic [NSLOT-1:0]            en_w;
  logic [NSLOT-1:0][LEN_W-1:0] len_w;
  logic [7:0]                  rd_w   [NSLOT];
  logic [7:0]                  byte_w [NSLOT];
  logic                        snap_w;
  logic [IDX_W-1:0]            idx_w;
  logic [SLOT_W-1:0]           wsel_w, rsel_w;

  assign wsel_w = wr_addr_i[ADDR_W-1 -: SLOT_W];
  assign rsel_w = rd_addr_i[ADDR_W-1 -: SLOT_W];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    ifg_slot #(
      .SLOT_ID(s), .PAY_DEPTH(PAY_DEPTH), .OFF_W(OFF_W),
      .LEN_W(LEN_W), .IDX_W(IDX_W), .DEF_VIC(DEF_VIC)
    ) i_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i && (int'(wsel_w) == s)),
      .wr_off_i  (wr_addr_i[OFF_W-1:0]),
      .wr_data_i (wr_data_i),
      .rd_off_i  (rd_addr_i[OFF_W-1:0]),
      .rd_data_o (rd_w[s]),
      .snap_i    (snap_w),
      .en_o      (en_w[s]),
      .len_o     (len_w[s]),
      .idx_i     (idx_w),
      .byte_o    (byte_w[s])
    );
  end

  ifg_seq #(.NSLOT(NSLOT), .LEN_W(LEN_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vsync_i    (vsync_i),
    .dvi_mode_i (dvi_mode_i),
    .en_i       (en_w),
    .len_i      (len_w),
    .snap_o     (snap_w),
    .valid_o    (pkt_valid_o),
    .sop_o      (pkt_sop_o),
    .slot_o     (pkt_slot_o),
    .idx_o      (idx_w)
  );

  always_comb begin
    rd_data_o = '0;
    for (int s = 0; s < NSLOT; s++)
      if (int'(rsel_w) == s) rd_data_o = rd_w[s];
  end

  always_comb begin
    pkt_data_o = '0;
    for (int s = 0; s < NSLOT; s++)
      if (pkt_valid_o && int'(pkt_slot_o) == s) pkt_data_o = byte_w[s];
  end
endmodule

// File: tb/test_infoframe_gen.sv
`timescale 1ns/1ps
module test_infoframe_gen;
  localparam int PD = 27;
  localparam logic [7:0] VIC = 8'd16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic       vsync = 1'b0, dvi = 1'b0;
  logic [7:0] rd_data, pkt_data;
  logic       pkt_valid, pkt_sop;
  logic [1:0] pkt_slot;

  always #2.5 clk = ~clk;

  infoframe_gen i_infoframe_gen (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .vsync_i(vsync), .dvi_mode_i(dvi),
    .pkt_valid_o(pkt_valid), .pkt_sop_o(pkt_sop), .pkt_data_o(pkt_data), .pkt_slot_o(pkt_slot)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [7:0] m_ctrl [3];
  logic [7:0] m_hdr  [3][3];
  logic [7:0] m_pay  [3][PD];

  logic [7:0] cap_b [256]; logic cap_s [256]; logic [1:0] cap_sl [256]; int cnt;
  logic [7:0] exp_b [256]; logic exp_s [256]; logic [1:0] exp_sl [256]; int nexp;

  task automatic check(bit ok, string req, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 3; s++) begin
      m_ctrl[s] = 8'h00;
      for (int n = 0; n < PD; n++) m_pay[s][n] = 8'h00;
    end
    m_hdr[0][0] = 8'h82; m_hdr[0][1] = 8'h02; m_hdr[0][2] = 8'h0D;
    m_hdr[1][0] = 8'h84; m_hdr[1][1] = 8'h01; m_hdr[1][2] = 8'h0A;
    m_hdr[2][0] = 8'h81; m_hdr[2][1] = 8'h01; m_hdr[2][2] = 8'h00;
    m_pay[0][1] = 8'h28;
    m_pay[0][3] = VIC;
  endtask

  function automatic int mlen(int s);
    return (int'(m_hdr[s][2]) > PD) ? PD : int'(m_hdr[s][2]);
  endfunction

  function automatic logic [7:0] mchk(int s);
    logic [7:0] sum;
    sum = m_hdr[s][0] + m_hdr[s][1] + m_hdr[s][2];
    for (int n = 0; n < mlen(s); n++) sum = sum + m_pay[s][n];
    return 8'h00 - sum;
  endfunction

  task automatic wr(int s, int off, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {2'(s), 6'(off)}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (s < 3) begin
      if (off == 0) m_ctrl[s] = d;
      else if (off >= 1 && off <= 3) m_hdr[s][off-1] = d;
      else if (off >= 8 && off < 8 + PD) m_pay[s][off-8] = d;
    end
  endtask

  task automatic rd_check(int s, int off, logic [7:0] expv, string req);
    @(negedge clk);
    rd_addr = {2'(s), 6'(off)};
    #1;
    check(rd_data === expv, req, rd_data, expv);
  endtask

  task automatic build_exp();
    nexp = 0;
    for (int s = 0; s < 3; s++) begin
      bit en;
      en = (s == 0) ? m_ctrl[0][1] : (m_ctrl[s] != 0);
      if (en) begin
        for (int b = 0; b < 4 + mlen(s); b++) begin
          if (b < 3)       exp_b[nexp] = m_hdr[s][b];
          else if (b == 3) exp_b[nexp] = mchk(s);
          else             exp_b[nexp] = m_pay[s][b-4];
          exp_s[nexp] = (b == 0);
          exp_sl[nexp] = 2'(s);
          nexp++;
        end
      end
    end
  endtask

  task automatic run_vsync(int cycles);
    @(negedge clk);
    vsync = 1'b1;
    cnt = 0;
    repeat (cycles) begin
      @(posedge clk);
      @(negedge clk);
      if (pkt_valid === 1'b1 && cnt < 256) begin
        cap_b[cnt] = pkt_data; cap_s[cnt] = pkt_sop; cap_sl[cnt] = pkt_slot;
        cnt++;
      end
    end
    vsync = 1'b0;
  endtask

  task automatic cmp_stream(string req);
    int m;
    check(cnt == nexp, {req, " byte count"}, cnt, nexp);
    m = (cnt < nexp) ? cnt : nexp;
    for (int i = 0; i < m; i++) begin
      check(cap_b[i] === exp_b[i], {req, " data"}, cap_b[i], exp_b[i]);
      check(cap_s[i] === exp_s[i], {req, " sop"}, int'(cap_s[i]), int'(exp_s[i]));
      check(cap_sl[i] === exp_sl[i], {req, " slot"}, cap_sl[i], exp_sl[i]);
    end
  endtask

  task automatic t_reset();
    check(pkt_valid === 1'b0, "R1 idle after reset", pkt_valid, 0);
    for (int s = 0; s < 3; s++) begin
      rd_check(s, 0, 8'h00, "R1 ctrl");
      for (int i = 0; i < 3; i++) rd_check(s, 1 + i, m_hdr[s][i], "R1 header");
      rd_check(s, 4, mchk(s), "R1 R3 default checksum");
    end
    rd_check(0, 9, 8'h28, "R1 aspect byte");
    rd_check(0, 11, VIC, "R1 vic byte");
    rd_check(0, 8, 8'h00, "R1 payload zero");
  endtask

  task automatic t_regmap();
    logic [7:0] c0;
    c0 = mchk(0);
    wr(0, 4, 8'h55);
    rd_check(0, 4, c0, "R2 checksum read-only");
    wr(3, 1, 8'hAA);
    rd_check(3, 1, 8'h00, "R2 slot3 unmapped");
    rd_check(0, 5, 8'h00, "R2 gap reads zero");
    rd_check(0, 1, m_hdr[0][0], "R2 slot3 write ignored");
    wr(1, 8 + 2, 8'h3C);
    rd_check(1, 10, 8'h3C, "R2 payload byte 3 offset");
  endtask

  task automatic t_chk_update();
    for (int n = 0; n < 10; n++) wr(1, 8 + n, 8'(8'h11 * (n + 1)));
    rd_check(1, 4, mchk(1), "R3 checksum audio");
    wr(1, 3, 8'h03);
    rd_check(1, 4, mchk(1), "R3 checksum shorter len");
    wr(1, 8 + 5, 8'hFF);
    rd_check(1, 4, mchk(1), "R3 byte beyond len excluded");
    wr(1, 3, 8'h0A);
    rd_check(1, 4, mchk(1), "R3 checksum restored len");
  endtask

  task automatic t_none();
    run_vsync(40);
    check(cnt == 0, "R11 nothing enabled", cnt, 0);
  endtask

  task automatic t_policy();
    wr(0, 0, 8'h01);
    run_vsync(40);
    check(cnt == 0, "R4 avi bit0 only", cnt, 0);
    wr(0, 0, 8'h00);
    wr(1, 0, 8'h02);
    build_exp();
    run_vsync(40);
    cmp_stream("R4 R5 audio only");
    wr(1, 0, 8'h00);
    wr(0, 0, 8'h02);
    build_exp();
    run_vsync(40);
    cmp_stream("R5 avi only");
  endtask

  task automatic t_order();
    wr(1, 0, 8'h02);
    wr(2, 0, 8'h01);
    wr(2, 3, 8'h04);
    for (int n = 0; n < 4; n++) wr(2, 8 + n, 8'(8'hA0 + n));
    build_exp();
    run_vsync(120);
    cmp_stream("R6 three packets");
  endtask

  task automatic t_clamp();
    wr(0, 0, 8'h00);
    wr(1, 0, 8'h00);
    wr(2, 3, 8'd40);
    for (int n = 0; n < PD; n++) wr(2, 8 + n, 8'(n * 7 + 3));
    rd_check(2, 4, mchk(2), "R7 R3 clamped checksum");
    build_exp();
    check(nexp == 4 + PD, "R7 model length", nexp, 4 + PD);
    run_vsync(60);
    cmp_stream("R7 clamped stream");
  endtask

  task automatic t_snapshot();
    wr(0, 0, 8'h02);
    wr(2, 0, 8'h00);
    build_exp();
    fork
      run_vsync(40);
      begin
        repeat (4) @(negedge clk);
        wr_en = 1'b1; wr_addr = {2'd0, 6'd9}; wr_data = 8'h18;
        @(negedge clk);
        wr_en = 1'b0;
      end
    join
    cmp_stream("R9 old contents during send");
    m_pay[0][1] = 8'h18;
    rd_check(0, 9, 8'h18, "R9 write landed in registers");
    build_exp();
    run_vsync(40);
    cmp_stream("R9 new contents next vsync");
  endtask

  task automatic t_busy_vsync();
    wr(1, 0, 8'h02);
    build_exp();
    fork
      run_vsync(60);
      begin
        repeat (5) @(negedge clk);
        vsync = 1'b0;
        @(negedge clk);
        vsync = 1'b1;
      end
    join
    cmp_stream("R10 vsync while busy");
  endtask

  task automatic t_dvi();
    dvi = 1'b1;
    run_vsync(40);
    check(cnt == 0, "R8 dvi at vsync", cnt, 0);
    dvi = 1'b0;
    fork
      run_vsync(60);
      begin
        repeat (4) @(negedge clk);
        dvi = 1'b1;
      end
    join
    check(cnt == 3, "R8 dvi mid sequence abort", cnt, 3);
    dvi = 1'b0;
    build_exp();
    run_vsync(60);
    cmp_stream("R8 recovery after dvi");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_chk_update();
    t_none();
    t_policy();
    t_order();
    t_clamp();
    t_snapshot();
    t_busy_vsync();
    t_dvi();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule